// File: doc/BRIEF.md
# Programmable Down-Counter Timer

A single timer channel with a 32-bit register port and an interrupt output. Software sets a start value, picks a counting mode, and enables the timer. The counter then steps down once per prescaled timing tick. The tick itself arrives as a single-cycle strobe from elsewhere in the chip, so no clock-domain crossing takes place inside the block.

The counter can be 16 or 32 bits wide. When it runs out, it can do one of three things: reload a programmable value, wrap to its all-ones value, or stop at zero. Reaching zero latches a raw interrupt flag, and an enable bit gates that flag onto the interrupt output. The start value can be written in two ways. An immediate write replaces the running count. A background write changes only the value used at the next reload, so a period can be retuned without a glitch.

Register accesses use a word index. The byte offsets are the index times four. Read data appears one cycle after the read.

Top module: `tdt_timer`

## Requirements
- R1: After reset, the control register reads 0x20, the count reads 0xFFFFFFFF, the raw interrupt reads 0, and `irq_o` is 0.
- R2: The word indices are 0 start value, 1 count (read-only), 2 control, 3 interrupt clear, 4 raw interrupt (bit 0), 5 masked interrupt (bit 0), 6 background value, and 7 unused. Read data is valid on the cycle after the read and holds until the next read. Index 7, the clear index and any undefined control bit read as 0. Writes to indices 1, 4 and 5 have no effect.
- R3: A write to index 0 stores the value and sets the count to that value at once, masked to the current width. It also restarts the prescale phase.
- R4: A write to index 6 changes only the stored reload value; the running count is untouched. Reads of index 0 and index 6 both return the stored reload value.
- R5: The count changes only on a step, that is a tick while control bit 7 (run) is 1 and the prescaler lets the tick through, or on a write to index 0.
- R6: Control bits 3:2 select the prescale. 00 steps on every tick, 01 on every 16th tick, and 10 or 11 on every 256th tick, counted from the last restart.
- R7: A step taken from a masked count of 1 to 0 sets the raw interrupt.
- R8: A step taken at a count of 0 with one-shot off depends on bit 6. With bit 6 = 1 (periodic), the count reloads the stored value masked to width. With bit 6 = 0 (free-running), it wraps to all ones for the width.
- R9: With control bit 0 = 1 (one-shot), the count stays at 0 once there, and no further interrupt is raised.
- R10: With control bit 1 = 0 (16-bit), every update leaves bits 31:16 of the count at 0, and the wrap value is 0x0000FFFF. With bit 1 = 1, the full 32 bits are used.
- R11: The masked interrupt (index 5) and `irq_o` both equal the raw interrupt AND control bit 5.
- R12: Any write to index 3 clears the raw interrupt. If a new interrupt is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle timing strobe |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data path, which gives a 16-bit narrow mode, and an 8-bit prescale counter. With these values the divide-by-256 prescale is reached in a few hundred ticks. The wrap values of both widths can be observed directly. The narrow mode is checked for masking of the upper half. The directed tests cover several situations:
- an immediate load against a background load, with a reload that follows;
- a one-shot run that halts at zero;
- an interrupt whose enable is switched on after it was raised.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_START = 3'd0;
  localparam logic [IDX_W-1:0] IDX_COUNT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CLEAR = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RAW   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_MASK  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_BGND  = 3'd6;

  // control field positions are decoded by software; keep order
  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       rsvd;      // bit 4
    logic [1:0] pre;       // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/tdt_prescale.sv
module tdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  localparam int MID_W = PRE_W / 2;

  logic [PRE_W-1:0] phase_q;
  logic             mid_full;
  logic             top_full;

  assign mid_full = &phase_q[MID_W-1:0];
  assign top_full = &phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) phase_q <= '0;
    else if (tick_i)                phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      2'b00:   step_o = tick_i && run_i;
      2'b01:   step_o = tick_i && run_i && mid_full;
      default: step_o = tick_i && run_i && top_full;
    endcase
  end

  p_div1_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && sel_i == 2'b00) |-> step_o);
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_i || !tick_i) |-> !step_o);
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              wide_i,
  input  logic              oneshot_i,
  input  logic              periodic_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              raw_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] cnt_q, cnt_d, mask, cnt_m;
  logic              raw_q, raw_set;

  assign mask  = wide_i ? '1 : NARROW_MASK;
  assign cnt_m = cnt_q & mask;

  always_comb begin
    cnt_d   = cnt_q;
    raw_set = 1'b0;
    if (load_we_i) begin
      cnt_d = load_val_i & mask;
    end else if (step_i) begin
      if (cnt_m != '0) begin
        cnt_d   = cnt_m - 1'b1;
        raw_set = (cnt_m == {{(DATA_W-1){1'b0}}, 1'b1});
      end else if (oneshot_i) begin
        cnt_d = cnt_m;
      end else if (periodic_i) begin
        cnt_d = reload_i & mask;
      end else begin
        cnt_d = mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (raw_set)    raw_q <= 1'b1;
      else if (clr_i) raw_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign raw_o = raw_q;

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_we_i) |=> $stable(cnt_q));
  p_one_to_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_we_i && cnt_m == {{(DATA_W-1){1'b0}}, 1'b1}) |=> raw_q);
  p_oneshot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_we_i && oneshot_i && cnt_m == '0) |=> (cnt_q == '0));
  p_narrow_upper_r10: assert property (@(posedge clk) disable iff (rst)
    (!wide_i && (step_i || load_we_i)) |=> (cnt_q[DATA_W-1:HALF] == '0));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(step_i && !load_we_i && cnt_m == {{(DATA_W-1){1'b0}}, 1'b1})) |=> !raw_q);
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              raw_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              load_we_o,
  output logic              clr_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q, rdata_q, rd_mux;
  logic              wr_en, rd_en;

  assign wr_en     = sel_i && wr_i;
  assign rd_en     = sel_i && !wr_i;
  assign load_we_o = wr_en && idx_i == IDX_START;
  assign clr_we_o  = wr_en && idx_i == IDX_CLEAR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= ctrl_t'(CTRL_RESET);
      reload_q <= '0;
    end else if (wr_en) begin
      if (idx_i == IDX_CTRL) begin
        ctrl_q      <= ctrl_t'(wdata_i[7:0]);
        ctrl_q.rsvd <= 1'b0;
      end
      if (idx_i == IDX_START || idx_i == IDX_BGND) reload_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (idx_i)
      IDX_START, IDX_BGND: rd_mux = reload_q;
      IDX_COUNT:           rd_mux = cnt_i;
      IDX_CTRL:            rd_mux = {{(DATA_W-8){1'b0}}, ctrl_q};
      IDX_RAW:             rd_mux[0] = raw_i;
      IDX_MASK:            rd_mux[0] = raw_i && ctrl_q.ie;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !ctrl_q.rsvd);
endmodule

// File: rtl/tdt_timer.sv
module tdt_timer
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [IDX_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, cnt;
  logic              load_we, clr_we, step, raw;

  tdt_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
    .idx_i(bus_addr_i), .wdata_i(bus_wdata_i), .cnt_i(cnt), .raw_i(raw),
    .ctrl_o(ctrl), .reload_o(reload), .load_we_o(load_we),
    .clr_we_o(clr_we), .rdata_o(bus_rdata_o)
  );

  tdt_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(ctrl.run),
    .restart_i(load_we), .sel_i(ctrl.pre), .step_o(step)
  );

  tdt_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .step_i(step), .load_we_i(load_we),
    .load_val_i(bus_wdata_i), .reload_i(reload), .wide_i(ctrl.wide),
    .oneshot_i(ctrl.oneshot), .periodic_i(ctrl.periodic), .clr_i(clr_we),
    .cnt_o(cnt), .raw_o(raw)
  );

  assign irq_o = raw && ctrl.ie;

  p_irq_needs_raw_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> raw);
endmodule

// File: tb/tdt_timer_tb.sv
module tdt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  tdt_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", 3'd2, 32'h20);
    expect_reg("R1 count", 3'd1, 32'hFFFF_FFFF);
    expect_reg("R1 raw", 3'd4, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_load_and_map;
    wr_reg(3'd0, 32'h0001_2345);
    expect_reg("R3 R10 narrow load", 3'd1, 32'h0000_2345);
    expect_reg("R2 start readback", 3'd0, 32'h0001_2345);
    wr_reg(3'd1, 32'h777);
    expect_reg("R2 count write ignored", 3'd1, 32'h0000_2345);
    expect_reg("R2 unused index", 3'd7, 32'h0);
    wr_reg(3'd2, 32'hFFFF_FF10);
    expect_reg("R2 ctrl undefined bits", 3'd2, 32'h0);
    wr_reg(3'd2, 32'h20);
    ticks(3);
    expect_reg("R5 disabled holds", 3'd1, 32'h0000_2345);
  endtask

  task automatic t_periodic;
    wr_reg(3'd2, 32'hE2);
    wr_reg(3'd0, 32'd3);
    ticks(2);
    expect_reg("R5 steps", 3'd1, 32'd1);
    expect_reg("R7 raw not yet", 3'd4, 32'd0);
    ticks(1);
    expect_reg("R7 zero", 3'd1, 32'd0);
    expect_reg("R7 raw set", 3'd4, 32'd1);
    expect_reg("R11 masked", 3'd5, 32'd1);
    check("R11 irq", {31'b0, irq}, 32'd1);
    wr_reg(3'd4, 32'h0);
    expect_reg("R2 raw write ignored", 3'd4, 32'd1);
    ticks(1);
    expect_reg("R8 periodic reload", 3'd1, 32'd3);
    wr_reg(3'd3, 32'h0);
    expect_reg("R12 cleared", 3'd4, 32'd0);
    check("R12 irq low", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_freerun;
    wr_reg(3'd2, 32'hA2);
    wr_reg(3'd0, 32'd1);
    ticks(1);
    expect_reg("R7 raw free", 3'd4, 32'd1);
    ticks(1);
    expect_reg("R8 wrap 32", 3'd1, 32'hFFFF_FFFF);
    wr_reg(3'd3, 32'h1);
    wr_reg(3'd2, 32'hA0);
    wr_reg(3'd0, 32'd1);
    ticks(2);
    expect_reg("R10 wrap 16", 3'd1, 32'h0000_FFFF);
    wr_reg(3'd3, 32'h1);
  endtask

  task automatic t_oneshot;
    wr_reg(3'd2, 32'hE3);
    wr_reg(3'd0, 32'd2);
    ticks(2);
    expect_reg("R9 reaches zero", 3'd1, 32'd0);
    expect_reg("R9 raw", 3'd4, 32'd1);
    wr_reg(3'd3, 32'h0);
    ticks(3);
    expect_reg("R9 holds zero", 3'd1, 32'd0);
    expect_reg("R9 no new irq", 3'd4, 32'd0);
  endtask

  task automatic t_background;
    wr_reg(3'd2, 32'hE2);
    wr_reg(3'd0, 32'd5);
    ticks(1);
    wr_reg(3'd6, 32'd2);
    expect_reg("R4 count untouched", 3'd1, 32'd4);
    expect_reg("R4 reload readback", 3'd0, 32'd2);
    expect_reg("R4 reload readback bg", 3'd6, 32'd2);
    ticks(5);
    expect_reg("R4 R8 new reload", 3'd1, 32'd2);
    wr_reg(3'd3, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] cfg [3];
    cfg[0] = 32'hE6; cfg[1] = 32'hEA; cfg[2] = 32'hEE;
    wr_reg(3'd2, cfg[0]);
    wr_reg(3'd0, 32'd100);
    ticks(15);
    expect_reg("R6 div16 wait", 3'd1, 32'd100);
    ticks(1);
    expect_reg("R6 div16 step", 3'd1, 32'd99);
    for (int k = 1; k < 3; k++) begin
      wr_reg(3'd2, cfg[k]);
      wr_reg(3'd0, 32'd100);
      ticks(255);
      expect_reg("R6 div256 wait", 3'd1, 32'd100);
      ticks(1);
      expect_reg("R6 div256 step", 3'd1, 32'd99);
    end
  endtask

  task automatic t_mask;
    wr_reg(3'd2, 32'hC2);
    wr_reg(3'd3, 32'h0);
    wr_reg(3'd0, 32'd1);
    ticks(1);
    expect_reg("R11 raw with ie off", 3'd4, 32'd1);
    expect_reg("R11 masked off", 3'd5, 32'd0);
    check("R11 irq off", {31'b0, irq}, 32'd0);
    wr_reg(3'd2, 32'hE2);
    check("R11 irq on", {31'b0, irq}, 32'd1);
    wr_reg(3'd3, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_load_and_map;
    t_periodic;
    t_freerun;
    t_oneshot;
    t_background;
    t_prescale;
    t_mask;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule